// File: doc/BRIEF.md
# Byte-Sequential Word Assembler

This block rebuilds a 16-bit conversion result from a source that sends it as two 8-bit bytes, one per edge of a single data strobe. The first byte arrives with the strobe's rising edge and the second with its falling edge. A byte-order level chooses whether the most significant byte arrives first. An overrange/underrange flag arrives alongside the data, and it is meaningful only in the period when the high byte is on the bus.

All inputs are asynchronous to the system clock. They pass through a multi-flop synchroniser, and the two strobe edges are found on the synchronised copy. The first byte waits in a staging register. When the second byte arrives, the full word and the clip flag load together, so all sixteen output bits and the flag change in one clock cycle. A one-cycle valid pulse marks that cycle.

The output is a valid-only stream. The converter cannot be paused, so there is no ready input and no back-pressure. A word stays on the outputs until the next word replaces it, and the consumer must take it on the valid pulse or before the next word completes.

Top module: `byte_word_assembler`

## Requirements
- R1: A rising edge of the synchronised strobe stores the byte on the bus as the first byte. A rise by itself changes no output and raises no valid pulse.
- R2: A falling edge of the synchronised strobe, when a rise has come before it, completes the word from the stored byte and the byte then on the bus.
- R3: When the order level is 0, the first byte is the high byte and becomes word bits 15:8, and the second byte becomes bits 7:0.
- R4: When the order level is 1, the first byte becomes word bits 7:0 and the second byte becomes bits 15:8.
- R5: The order level is taken at the rising edge and held for that word. A change of the order level between the rise and the fall has no effect on that word.
- R6: The clip output (1 = over/underrange, 0 = normal) is the flag value present at whichever strobe edge carried the high byte. The flag value at the other edge is ignored.
- R7: The word and clip outputs change only in the cycle that valid is high. All 16 bits and the clip flag load together, and they keep their previous value from the rise until that cycle.
- R8: The valid output is high for exactly one cycle per completed word, in the cycle the new word appears.
- R9: A falling edge with no rising edge since reset produces no valid pulse and leaves the word unchanged.
- R10: Synchronous reset clears the word, the clip flag and valid on the next clock edge, and it discards a half-received word.
- R11: With the default two-stage synchroniser, the new word and the valid pulse appear after the third rising clock edge that follows the fall of the strobe input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_in | input | 1 | Asynchronous data strobe from the converter |
| byte_in | input | 8 | Asynchronous byte bus |
| order_in | input | 1 | Byte order: 0 = high byte first, 1 = low byte first |
| clip_in | input | 1 | Asynchronous over/underrange flag |
| word_out | output | 16 | Assembled word |
| clip_out | output | 1 | Clip flag taken with the high byte |
| word_valid | output | 1 | One-cycle pulse when word_out and clip_out update |

## Verification
A wrong byte order or a stale staging register shows up as swapped or mismatched halves of word_out in the very cycle of the valid pulse, three clocks after the strobe falls. A wrong clip source shows up the same way on clip_out. If the order level is held badly, or a word is left half-received, the result is a wrong word, or a valid pulse appearing or going missing at that same cycle. An early or partial update is caught mid-word, while the strobe is high and the outputs must still show the previous word.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    HIGH_FIRST = 1'b0,
    LOW_FIRST  = 1'b1
  } order_e;
endpackage

// File: rtl/bwa_sync.sv
module bwa_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= async_i;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/bwa_edge.sv
module bwa_edge (
  input  logic clk,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) prev_q <= level_i;

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/bwa_capture.sv
module bwa_capture
  import bwa_pkg::*;
#(
  parameter int unsigned BW = 8,
  localparam int unsigned WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [BW-1:0] byte_i,
  input  logic          order_i,
  input  logic          clip_i,
  output logic [WW-1:0] word_o,
  output logic          clip_o,
  output logic          valid_o
);
  order_e        order_q;
  logic [BW-1:0] stage_q;
  logic          stage_clip_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q      <= HIGH_FIRST;
      stage_q      <= '0;
      stage_clip_q <= 1'b0;
      armed_q      <= 1'b0;
      word_o       <= '0;
      clip_o       <= 1'b0;
      valid_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        stage_q <= byte_i;
        order_q <= order_e'(order_i);
        armed_q <= 1'b1;
        if (order_e'(order_i) == HIGH_FIRST) stage_clip_q <= clip_i;
      end else if (fall_i && armed_q) begin
        armed_q <= 1'b0;
        valid_o <= 1'b1;
        if (order_q == HIGH_FIRST) begin
          word_o <= {stage_q, byte_i};
          clip_o <= stage_clip_q;
        end else begin
          word_o <= {byte_i, stage_q};
          clip_o <= clip_i;
        end
      end
    end
  end
endmodule

// File: rtl/byte_word_assembler.sv
module byte_word_assembler
  import bwa_pkg::*;
#(
  parameter int unsigned BYTE_WIDTH = bwa_pkg::BYTE_W,
  parameter int unsigned SYNC_DEPTH = bwa_pkg::SYNC_STAGES,
  localparam int unsigned BUS_W  = BYTE_WIDTH + 3,
  localparam int unsigned WORD_W = 2 * BYTE_WIDTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe_in,
  input  logic [BYTE_WIDTH-1:0] byte_in,
  input  logic                  order_in,
  input  logic                  clip_in,
  output logic [WORD_W-1:0]     word_out,
  output logic                  clip_out,
  output logic                  word_valid
);
  logic [BUS_W-1:0]      raw_bus, sync_bus;
  logic                  s_strobe, s_order, s_clip;
  logic [BYTE_WIDTH-1:0] s_byte;
  logic                  rise, fall;

  assign raw_bus = {strobe_in, order_in, clip_in, byte_in};
  assign {s_strobe, s_order, s_clip, s_byte} = sync_bus;

  bwa_sync #(.WIDTH(BUS_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .async_i(raw_bus),
    .sync_o (sync_bus)
  );

  bwa_edge u_edge (
    .clk    (clk),
    .level_i(s_strobe),
    .rise_o (rise),
    .fall_o (fall)
  );

  bwa_capture #(.BW(BYTE_WIDTH)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise),
    .fall_i (fall),
    .byte_i (s_byte),
    .order_i(s_order),
    .clip_i (s_clip),
    .word_o (word_out),
    .clip_o (clip_out),
    .valid_o(word_valid)
  );
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_in,
  input logic [WORD_W-1:0] word_out,
  input logic              clip_out,
  input logic              word_valid
);
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !$past(rst)) |-> ($stable(word_out) && $stable(clip_out)));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (word_out == '0 && !clip_out && !word_valid));

  p_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ($past(strobe_in, SYNC_DEPTH + 2) && !$past(strobe_in, SYNC_DEPTH + 1)));
endmodule

bind byte_word_assembler bwa_checker #(.WORD_W(WORD_W), .SYNC_DEPTH(SYNC_DEPTH)) u_bwa_checker (
  .clk       (clk),
  .rst       (rst),
  .strobe_in (strobe_in),
  .word_out  (word_out),
  .clip_out  (clip_out),
  .word_valid(word_valid)
);

// File: tb/test_byte_word_assembler.sv
module test_byte_word_assembler;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_in = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        order_in = 1'b0;
  logic        clip_in = 1'b0;
  logic [15:0] word_out;
  logic        clip_out;
  logic        word_valid;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  bit done = 1'b0;

  byte_word_assembler i_byte_word_assembler (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .byte_in(byte_in),
    .order_in(order_in), .clip_in(clip_in), .word_out(word_out),
    .clip_out(clip_out), .word_valid(word_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (!rst && word_valid) vcount++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] hi, input logic [7:0] lo,
                           input logic order, input logic clp);
    logic [15:0] prev_w;
    logic        prev_c;
    int          v0;
    prev_w = word_out;
    prev_c = clip_out;
    v0 = vcount;
    order_in = order;
    byte_in  = order ? lo : hi;
    clip_in  = order ? ~clp : clp;
    tick(2);
    strobe_in = 1'b1;
    tick(4);
    #1;
    check(word_out == prev_w, "R7 word held after rise", word_out, prev_w);
    check(clip_out == prev_c, "R7 clip held after rise", clip_out, prev_c);
    check(vcount == v0, "R1 no pulse on rise", vcount, v0);
    order_in = ~order;
    byte_in  = order ? hi : lo;
    clip_in  = order ? clp : ~clp;
    tick(2);
    strobe_in = 1'b0;
    tick(2);
    check(word_valid == 1'b0, "R11 valid not early", word_valid, 0);
    tick(1);
    check(word_valid == 1'b1, "R11 R2 valid after fall", word_valid, 1);
    check(word_out == {hi, lo}, order ? "R4 R5 word low-first" : "R3 R5 word high-first",
          word_out, {hi, lo});
    check(clip_out == clp, "R6 clip from high-byte edge", clip_out, clp);
    tick(1);
    check(word_valid == 1'b0, "R8 pulse one cycle", word_valid, 0);
    #1;
    check(vcount == v0 + 1, "R8 one pulse per word", vcount, v0 + 1);
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    check(word_out == 16'h0, "R10 reset word", word_out, 0);
    check(clip_out == 1'b0, "R10 reset clip", clip_out, 0);
    check(word_valid == 1'b0, "R10 reset valid", word_valid, 0);

    for (int ord = 0; ord < 2; ord++) begin
      for (int i = 0; i < 256; i++) begin
        send_word(8'(i), 8'((i * 37 + 11) & 255), ord[0], 1'(i & 1) ^ ord[0]);
      end
    end

    order_in = 1'b0;
    byte_in  = 8'hA5;
    strobe_in = 1'b1;
    tick(6);
    rst = 1'b1;
    tick(3);
    check(word_out == 16'h0, "R10 reset clears word", word_out, 0);
    check(clip_out == 1'b0, "R10 reset clears clip", clip_out, 0);
    begin
      int v0;
      rst = 1'b0;
      tick(3);
      v0 = vcount;
      byte_in = 8'h3C;
      strobe_in = 1'b0;
      tick(8);
      #1;
      check(vcount == v0, "R9 R10 fall without rise ignored", vcount, v0);
      check(word_out == 16'h0, "R9 word unchanged", word_out, 0);
    end

    send_word(8'hFF, 8'h00, 1'b1, 1'b1);
    send_word(8'h00, 8'hFF, 1'b0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule